// File: doc/BRIEF.md
# Digitally Calibrated Real-Time-Clock Prescaler

This block turns a nominal 32.768 kHz oscillator clock into a one-cycle 1 Hz tick for downstream timekeeping counters. It corrects crystal frequency error digitally rather than by trimming load capacitance. A fixed 64-minute correction cycle runs alongside the divider. In a programmed number of its minutes, the first second is made shorter or longer by a whole number of 256 Hz counts.

The divider has two stages. A first stage divides the oscillator by 128 to make a 256 Hz count strobe, and its midpoint bit gives a 512 Hz test square wave. A second stage counts 256 Hz strobes per second. A positive correction injects two extra counts into that stage, so the second lasts 32512 oscillator cycles. A negative correction suppresses one count, so the second lasts 32896 cycles. The test signal is taken before the correction point, so calibration never changes it. Position outputs report the second within the minute and the minute within the correction cycle.

All divider ratios are parameters, so a bench can shrink a full correction cycle to a few thousand clocks.

Top module: `rtc_cal_prescaler`

## Requirements
- R1: While reset is asserted, `tick_1hz_o` is 0, `sec_idx_o` and `min_idx_o` are 0, and `ft_512_o` is 0.
- R2: An unadjusted second lasts exactly SUB_DIV*PRE_DIV oscillator cycles (32768 with default parameters).
- R3: With `cal_i[5]`=1 (speed up) and magnitude N=`cal_i[4:0]`, second 0 of each minute 0 to 2N-1 of the cycle lasts (SUB_DIV-2)*PRE_DIV cycles.
- R4: With `cal_i[5]`=0 (slow down) and magnitude N, second 0 of each minute 0 to 2N-1 lasts (SUB_DIV+1)*PRE_DIV cycles.
- R5: Seconds other than second 0 are never adjusted. Minutes at or beyond 2N are never adjusted, and this always includes minutes 62 and 63. N=0 adjusts nothing.
- R6: The calibration input is captured once on the first clock after reset and again at each wrap of the 64-minute cycle. A value written in the middle of a cycle has no effect until the next cycle starts.
- R7: `sec_idx_o` counts 0 to SEC_PER_MIN-1 and `min_idx_o` counts 0 to 63, and both wrap. They change only in the cycle in which the tick is high, and at that point they already show the new second.
- R8: While `stop_i`=1, all counters and both position outputs hold their values, no tick is produced and `ft_512_o` does not change. When `stop_i` returns to 0, counting resumes from the held state. Stopped cycles do not count toward the length of a second.
- R9: With `ft_en_i`=1 and `irq_en_i`=0, `ft_512_o` is a square wave with a period of PRE_DIV/2 running cycles (512 Hz by default), whatever the calibration. It is held at 0 when `ft_en_i`=0 or `irq_en_i`=1.
- R10: `tick_1hz_o` is high for exactly one oscillator cycle per second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Oscillator clock |
| rst_osc_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| stop_i | input | 1 | 1 freezes the whole divider and cycle state |
| cal_i | input | 6 | Bit 5 sign (1 = faster), bits 4:0 magnitude N |
| ft_en_i | input | 1 | Enables the 512 Hz test output |
| irq_en_i | input | 1 | 1 inhibits the test output |
| tick_1hz_o | output | 1 | One-cycle pulse at the end of each second |
| ft_512_o | output | 1 | 512 Hz test square wave |
| min_idx_o | output | $clog2(CYCLE_MIN) | Minute within the correction cycle |
| sec_idx_o | output | $clog2(SEC_PER_MIN) | Second within the minute |

## Verification
The hardest case to reach is the cycle boundary. A calibration change made in the middle of a cycle must be ignored until the next wrap, and that wrap comes only after every second of the cycle has run. The bench shrinks the divider parameters so that one 64-minute cycle takes about 8000 clocks. It runs four full cycles, changing the sign and magnitude in the middle of each, including N=0 and N=31. Each measured second is compared with a length predicted from the setting captured at that cycle's start. A stop window is also placed in the middle of a second, to show that stopped clocks are excluded from its length.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
  localparam int CAL_MAG_W = 5;
  localparam int CAL_W     = CAL_MAG_W + 1;

  typedef enum logic [1:0] {
    ADJ_NONE = 2'd0,
    ADJ_FAST = 2'd1,
    ADJ_SLOW = 2'd2
  } adj_e;
endpackage

// File: rtl/rtc_pre_div.sv
module rtc_pre_div #(
  parameter int PRE_DIV = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic strobe,
  output logic half_bit
);
  localparam int PW = $clog2(PRE_DIV);
  localparam logic [PW-1:0] LAST = PW'(PRE_DIV - 1);

  logic [PW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (run) begin
      if (cnt_q == LAST) cnt_d = '0;
      else               cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign strobe   = run && (cnt_q == LAST);
  assign half_bit = cnt_q[PW-2];
endmodule

// File: rtl/rtc_sec_div.sv
module rtc_sec_div
  import rtc_cal_pkg::*;
#(
  parameter int SUB_DIV = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  input  adj_e adj,
  output logic tick_raw
);
  localparam int SW = $clog2(SUB_DIV + 1);
  localparam logic [SW-1:0] TERM_NONE = SW'(SUB_DIV - 1);
  localparam logic [SW-1:0] TERM_FAST = SW'(SUB_DIV - 3);
  localparam logic [SW-1:0] TERM_SLOW = SW'(SUB_DIV);

  logic [SW-1:0] cnt_q, cnt_d, term;

  always_comb begin
    unique case (adj)
      ADJ_FAST: term = TERM_FAST;
      ADJ_SLOW: term = TERM_SLOW;
      default:  term = TERM_NONE;
    endcase
  end

  assign tick_raw = strobe && (cnt_q == term);

  always_comb begin
    cnt_d = cnt_q;
    if (strobe) begin
      if (tick_raw) cnt_d = '0;
      else          cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/rtc_cycle_pos.sv
module rtc_cycle_pos
  import rtc_cal_pkg::*;
#(
  parameter int SEC_PER_MIN = 60,
  parameter int CYCLE_MIN   = 64
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           tick_raw,
  input  logic [CAL_W-1:0]               cal_in,
  output adj_e                           adj,
  output logic [$clog2(SEC_PER_MIN)-1:0] sec_idx,
  output logic [$clog2(CYCLE_MIN)-1:0]   min_idx
);
  localparam int SW = $clog2(SEC_PER_MIN);
  localparam int MW = $clog2(CYCLE_MIN);
  localparam logic [SW-1:0] SEC_LAST = SW'(SEC_PER_MIN - 1);
  localparam logic [MW-1:0] MIN_LAST = MW'(CYCLE_MIN - 1);

  logic [SW-1:0]    sec_q, sec_d;
  logic [MW-1:0]    min_q, min_d;
  logic [CAL_W-1:0] cal_q, cal_d;
  logic             primed_q;
  logic             sec_wrap, cyc_wrap, load;
  logic [CAL_MAG_W:0] span;

  assign sec_wrap = tick_raw && (sec_q == SEC_LAST);
  assign cyc_wrap = sec_wrap && (min_q == MIN_LAST);
  assign load     = !primed_q || cyc_wrap;

  always_comb begin
    sec_d = sec_q;
    min_d = min_q;
    cal_d = cal_q;
    if (tick_raw) sec_d = sec_wrap ? '0 : sec_q + 1'b1;
    if (sec_wrap) min_d = cyc_wrap ? '0 : min_q + 1'b1;
    if (load)     cal_d = cal_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q    <= '0;
      min_q    <= '0;
      cal_q    <= '0;
      primed_q <= 1'b0;
    end else begin
      sec_q    <= sec_d;
      min_q    <= min_d;
      cal_q    <= cal_d;
      primed_q <= 1'b1;
    end
  end

  assign span = {cal_q[CAL_MAG_W-1:0], 1'b0};

  always_comb begin
    adj = ADJ_NONE;
    if ((sec_q == '0) && ((MW+1)'(min_q) < (MW+1)'(span)))
      adj = cal_q[CAL_MAG_W] ? ADJ_FAST : ADJ_SLOW;
  end

  assign sec_idx = sec_q;
  assign min_idx = min_q;
endmodule

// File: rtl/rtc_cal_prescaler.sv
module rtc_cal_prescaler
  import rtc_cal_pkg::*;
#(
  parameter int PRE_DIV     = 128,
  parameter int SUB_DIV     = 256,
  parameter int SEC_PER_MIN = 60,
  parameter int CYCLE_MIN   = 64
) (
  input  logic                           clk_osc,
  input  logic                           rst_osc_n,
  input  logic                           stop_i,
  input  logic [CAL_W-1:0]               cal_i,
  input  logic                           ft_en_i,
  input  logic                           irq_en_i,
  output logic                           tick_1hz_o,
  output logic                           ft_512_o,
  output logic [$clog2(CYCLE_MIN)-1:0]   min_idx_o,
  output logic [$clog2(SEC_PER_MIN)-1:0] sec_idx_o
);
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;
  logic       run, strobe, half_bit, tick_raw, tick_q;
  adj_e       adj;

  always_ff @(posedge clk_osc or negedge rst_osc_n) begin
    if (!rst_osc_n) rst_pipe_q <= 2'b00;
    else            rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  assign run = !stop_i;

  rtc_pre_div #(.PRE_DIV(PRE_DIV)) u_pre (
    .clk(clk_osc), .rst_n(rst_sync_n), .run(run),
    .strobe(strobe), .half_bit(half_bit)
  );

  rtc_sec_div #(.SUB_DIV(SUB_DIV)) u_sec (
    .clk(clk_osc), .rst_n(rst_sync_n), .strobe(strobe),
    .adj(adj), .tick_raw(tick_raw)
  );

  rtc_cycle_pos #(.SEC_PER_MIN(SEC_PER_MIN), .CYCLE_MIN(CYCLE_MIN)) u_pos (
    .clk(clk_osc), .rst_n(rst_sync_n), .tick_raw(tick_raw), .cal_in(cal_i),
    .adj(adj), .sec_idx(sec_idx_o), .min_idx(min_idx_o)
  );

  always_ff @(posedge clk_osc or negedge rst_sync_n) begin
    if (!rst_sync_n) tick_q <= 1'b0;
    else             tick_q <= tick_raw;
  end

  assign tick_1hz_o = tick_q;
  assign ft_512_o   = ft_en_i && !irq_en_i && half_bit;
endmodule

// File: rtl/rtc_cal_prescaler_chk.sv
module rtc_cal_prescaler_chk #(
  parameter int PRE_DIV     = 128,
  parameter int SUB_DIV     = 256,
  parameter int SEC_PER_MIN = 60,
  parameter int CYCLE_MIN   = 64
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           stop,
  input logic                           tick,
  input logic [$clog2(SEC_PER_MIN)-1:0] sec_idx,
  input logic [$clog2(CYCLE_MIN)-1:0]   min_idx
);
  localparam int LEN_NORM = SUB_DIV * PRE_DIV;
  localparam int LEN_FAST = (SUB_DIV - 2) * PRE_DIV;
  localparam int LEN_SLOW = (SUB_DIV + 1) * PRE_DIV;

  int   gap_q;
  logic seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= 0;
      seen_q <= 1'b0;
    end else begin
      seen_q <= seen_q || tick;
      if (tick)       gap_q <= stop ? 0 : 1;
      else if (!stop) gap_q <= gap_q + 1;
    end
  end

  // R10
  tick_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  // R8
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> ($stable(sec_idx) && $stable(min_idx)));

  // R8
  stop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> !tick);

  // R7
  pos_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_idx != $past(sec_idx)) |-> tick);

  // R2
  len_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && seen_q) |-> (gap_q == LEN_NORM || gap_q == LEN_FAST || gap_q == LEN_SLOW));

  // R5
  adj_place_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && seen_q && gap_q != LEN_NORM) |->
      (sec_idx == 1 && int'(min_idx) < CYCLE_MIN - 2));
endmodule

bind rtc_cal_prescaler rtc_cal_prescaler_chk #(
  .PRE_DIV(PRE_DIV), .SUB_DIV(SUB_DIV),
  .SEC_PER_MIN(SEC_PER_MIN), .CYCLE_MIN(CYCLE_MIN)
) u_chk (
  .clk(clk_osc), .rst_n(rst_sync_n), .stop(stop_i), .tick(tick_1hz_o),
  .sec_idx(sec_idx_o), .min_idx(min_idx_o)
);

// File: tb/tb_rtc_cal_prescaler.sv
`timescale 1ns/1ps
module tb_rtc_cal_prescaler;
  localparam int PRE_DIV = 4;
  localparam int SUB_DIV = 8;
  localparam int SPM     = 4;
  localparam int CYC     = 64;
  localparam int SPC     = SPM * CYC;
  localparam int NTICK   = 4 * SPC;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       stop;
  logic [5:0] cal;
  logic       ft_en, irq_en;
  logic       tick, ft;
  logic [5:0] min_idx;
  logic [1:0] sec_idx;

  always #5 clk = ~clk;

  rtc_cal_prescaler #(.PRE_DIV(PRE_DIV), .SUB_DIV(SUB_DIV),
                      .SEC_PER_MIN(SPM), .CYCLE_MIN(CYC)) dut (
    .clk_osc(clk), .rst_osc_n(rst_n), .stop_i(stop), .cal_i(cal),
    .ft_en_i(ft_en), .irq_en_i(irq_en), .tick_1hz_o(tick), .ft_512_o(ft),
    .min_idx_o(min_idx), .sec_idx_o(sec_idx)
  );

  typedef struct {int len; int mn; int sc; string tag;} exp_t;
  exp_t q[$];

  int  checks = 0, errors = 0, ntick = 0, gap = 0;
  bit  done = 0;
  logic prev_ft, prev_tick, prev_tog_ok;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // driver: expected second lengths and post-tick positions per cycle
  task automatic push_expected();
    bit sgn[4] = '{1, 0, 0, 1};
    int mag[4] = '{3, 31, 0, 31};
    for (int k = 0; k < NTICK; k++) begin
      exp_t e;
      int c = k / SPC, w = k % SPC, m = w / SPM, s = w % SPM, nw = (k + 1) % SPC;
      e.len = SUB_DIV * PRE_DIV; e.tag = (mag[c] == 0) ? "R5" : "R2";
      if (s == 0 && m < 2 * mag[c]) begin
        e.len = sgn[c] ? (SUB_DIV - 2) * PRE_DIV : (SUB_DIV + 1) * PRE_DIV;
        e.tag = sgn[c] ? "R3" : "R4";
      end else if (m >= 62) e.tag = "R5";
      if (c == 1 && m >= 2) e.tag = "R6";
      e.mn = nw / SPM; e.sc = nw % SPM;
      q.push_back(e);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (tick && prev_tick) chk(0, "R10 double tick", 1, 0);
      if (tick) begin
        exp_t e;
        if (q.size() == 0) chk(0, "R7 extra tick", ntick, NTICK);
        else begin
          e = q.pop_front();
          if (ntick > 0) chk(gap == e.len, e.tag, gap, e.len);
          chk(int'(min_idx) == e.mn, "R7 min", int'(min_idx), e.mn);
          chk(int'(sec_idx) == e.sc, "R7 sec", int'(sec_idx), e.sc);
        end
        ntick++;
        gap = 0;
      end
      if (ntick > 0 && prev_tog_ok && ft_en && !irq_en)
        chk(ft != prev_ft, "R9 toggle", ft, !prev_ft);
      prev_tog_ok = ft_en && !irq_en && !stop;
      prev_ft = ft;
      prev_tick = tick;
      if (!stop) gap++;
    end
  end

  initial begin
    rst_n = 0; stop = 0; cal = 6'b1_00011; ft_en = 1; irq_en = 0;
    prev_ft = 0; prev_tick = 0; prev_tog_ok = 0;
    push_expected();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(tick == 0, "R1 tick", tick, 0);
    chk(min_idx == 0, "R1 min", int'(min_idx), 0);
    chk(sec_idx == 0, "R1 sec", int'(sec_idx), 0);
    chk(ft == 0, "R1 ft", ft, 0);
    @(posedge clk); #1 rst_n = 1;

    wait (ntick == 40);  @(posedge clk); #1 cal = 6'b0_11111; // R6: next cycle
    wait (ntick == 300); @(posedge clk); #1 cal = 6'b0_00000;
    wait (ntick == 550);
    repeat (3) @(posedge clk); #1 irq_en = 1;
    for (int i = 0; i < 6; i++) begin @(negedge clk); chk(ft == 0, "R9 irq gate", ft, 0); end
    @(posedge clk); #1 irq_en = 0; ft_en = 0;
    for (int i = 0; i < 6; i++) begin @(negedge clk); chk(ft == 0, "R9 en gate", ft, 0); end
    @(posedge clk); #1 ft_en = 1;
    wait (ntick == 600); @(posedge clk); #1 cal = 6'b1_11111;

    wait (ntick == 900);
    repeat (5) @(posedge clk); #1 stop = 1;
    begin
      logic [5:0] m0; logic [1:0] s0; logic f0; bit ok_t, ok_p, ok_f;
      @(negedge clk); m0 = min_idx; s0 = sec_idx; f0 = ft;
      ok_t = 1; ok_p = 1; ok_f = 1;
      for (int i = 0; i < 50; i++) begin
        @(negedge clk);
        if (tick) ok_t = 0;
        if (min_idx != m0 || sec_idx != s0) ok_p = 0;
        if (ft != f0) ok_f = 0;
      end
      chk(ok_t, "R8 no tick", !ok_t, 0);
      chk(ok_p, "R8 position held", int'(sec_idx), int'(s0));
      chk(ok_f, "R8 ft held", ft, f0);
    end
    @(posedge clk); #1 stop = 0;

    wait (ntick == NTICK);
    repeat (4) @(negedge clk);
    chk(q.size() == 0, "R7 all seconds seen", q.size(), 0);
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog ticks=%0d expected=%0d", ntick, NTICK);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule